// File: doc/BRIEF.md
# Per-Line Programmable Edge Detector

This block watches a wide bus of single-bit event lines, up to 256 by default. Every line has its own two-bit edge selector and its own mask bit. A line can look for a rising edge, a falling edge, either edge, or nothing at all. In every clock cycle the block produces a registered vector with one bit per line, marking which lines showed their selected edge. It also produces a single flag that is set whenever any bit of that vector is set.

Software sets the block up through a simple word-wide register port. Each write is a single cycle and each read is combinational. A global collection switch gates all detection. The previous-value reference for each line is captured only while collection is on. Because of that, the first cycle after collection is switched on never reports an edge, so a stale reference cannot cause a false event.

The register layout uses word addresses:

- Address 0 holds the collection switch in bit 0.
- The edge-selector words come next, sixteen two-bit fields per 32-bit word.
- The mask words follow, thirty-two mask bits per word.

Top module: `edge_sentinel`

## Requirements
- R1: Edge code 2'b00 (rising) flags a line when its input goes 0 to 1. A 1 to 0 change on that line is not flagged.
- R2: Edge code 2'b01 (falling) flags a line when its input goes 1 to 0. A 0 to 1 change on that line is not flagged.
- R3: Edge code 2'b10 (toggle) flags a line on every change of its input, in either direction.
- R4: Edge code 2'b11 never flags the line.
- R5: When a line's mask bit is 1, that line is never flagged, while unmasked lines in the same cycle are still flagged. All mask bits reset to 0.
- R6: Word address 0, bit 0, is the collection switch, and it resets to 0. While it reads 0, the output vector is all zeros from the next cycle on, whatever the inputs do.
- R7: In the first cycle after the collection switch goes from 0 to 1, no line is flagged, even if an input differs from the value it had when collection last ran.
- R8: The any-event flag is 1 exactly in the cycles where the output vector is non-zero.
- R9: The register map is as follows:
  - Line k's edge code sits in bits [2*(k%16)+1 : 2*(k%16)] of word address 1+k/16.
  - Line k's mask bit is bit k%32 of word address 17+k/32 (these addresses are for 256 lines).
  - Written words read back unchanged, and all of them reset to 0.
  - Addresses outside the map read 0.
- R10: A register write takes effect at the clock edge that captures it. Detection at that same edge still uses the settings from before the write.
- R11: An input change that is present before clock edge n appears on the output vector after edge n, and it stays there for exactly one cycle if the inputs do not change again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | WORD_W | Register write data |
| regRdata | output | WORD_W | Combinational read data for regAddr |
| evIn | input | NUM_LINES | Event input lines |
| detOut | output | NUM_LINES | Registered per-line edge flags |
| anyOut | output | 1 | Registered OR of all edge flags |

## Verification
A register write and an edge on the line that the write reconfigures can land on the same clock edge. The bench provokes this by driving both before one edge: it rewrites line 5 from rising to falling while line 5 rises. It then expects line 5 to be flagged under the old rising setting, and on the following fall it expects the new falling setting to apply. A second pairing happens when collection is re-enabled while an input already differs from its stale reference. The bench judges this case by requiring a silent first cycle, after which detection resumes normally.

// File: rtl/edge_sentinel_pkg.sv
package edge_sentinel_pkg;

  // Per-line edge selector encoding
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edgeKind_t;

  // Strobes from the register block to the datapath
  typedef struct packed {
    logic collectEn;  // collection switch
    logic refValid;   // previous-value reference has been captured under collection
  } senseStrobes_t;

endpackage

// File: rtl/edge_sentinel_regs.sv
module edge_sentinel_regs
  import edge_sentinel_pkg::*;
#(
  parameter int NUM_LINES = 256,  // multiple of WORD_W
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [WORD_W-1:0]      regWdata,
  output logic [WORD_W-1:0]      regRdata,
  output senseStrobes_t          strb,
  output logic [2*NUM_LINES-1:0] edgeSel,
  output logic [NUM_LINES-1:0]   maskVec
);

  localparam int FIELDS_PER_WORD = WORD_W / 2;
  localparam int CTRL_WORDS      = (NUM_LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int MASK_WORDS      = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int CTRL_BASE       = 1;
  localparam int MASK_BASE       = CTRL_BASE + CTRL_WORDS;

  logic collectQ;
  logic refValidQ;
  logic [CTRL_WORDS*WORD_W-1:0] ctrlFlat;
  logic [MASK_WORDS*WORD_W-1:0] maskFlat;

  // Collection switch and reference-valid tracker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collectQ  <= 1'b0;
      refValidQ <= 1'b0;
    end else begin
      if (regWe && regAddr == '0) collectQ <= regWdata[0];
      refValidQ <= collectQ;
    end
  end

  // Edge selector words
  for (genvar w = 0; w < CTRL_WORDS; w++) begin : g_ctrl
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else if (regWe && regAddr == ADDR_W'(CTRL_BASE + w)) wordQ <= regWdata;
    end
    assign ctrlFlat[w*WORD_W +: WORD_W] = wordQ;
  end

  // Mask words
  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else if (regWe && regAddr == ADDR_W'(MASK_BASE + w)) wordQ <= regWdata;
    end
    assign maskFlat[w*WORD_W +: WORD_W] = wordQ;
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == '0) regRdata = WORD_W'(collectQ);
    for (int w = 0; w < CTRL_WORDS; w++)
      if (regAddr == ADDR_W'(CTRL_BASE + w)) regRdata = ctrlFlat[w*WORD_W +: WORD_W];
    for (int w = 0; w < MASK_WORDS; w++)
      if (regAddr == ADDR_W'(MASK_BASE + w)) regRdata = maskFlat[w*WORD_W +: WORD_W];
  end

  assign strb.collectEn = collectQ;
  assign strb.refValid  = refValidQ;
  assign edgeSel        = ctrlFlat[2*NUM_LINES-1:0];
  assign maskVec        = maskFlat[NUM_LINES-1:0];

  // R6: a write to address 0 sets the switch from data bit 0
  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == '0) |=> (strb.collectEn == $past(regWdata[0])));

  // R7: the reference is never marked valid in the cycle the switch turns on
  assert_ref_lags_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.collectEn) |-> !strb.refValid);

endmodule

// File: rtl/edge_sentinel_core.sv
module edge_sentinel_core
  import edge_sentinel_pkg::*;
#(
  parameter int NUM_LINES = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   evIn,
  input  senseStrobes_t          strb,
  input  logic [2*NUM_LINES-1:0] edgeSel,
  input  logic [NUM_LINES-1:0]   maskVec,
  output logic [NUM_LINES-1:0]   detOut,
  output logic                   anyOut
);

  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] gated;
  logic [NUM_LINES-1:0] detQ;
  logic                 anyQ;
  logic                 live;

  // Previous-value reference, captured only while collecting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else if (strb.collectEn) prevQ <= evIn;
  end

  // Per-line edge decode
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    edgeKind_t kind;
    logic      hitBit;
    assign kind = edgeKind_t'(edgeSel[2*k +: 2]);
    always_comb begin
      case (kind)
        EDGE_RISE: hitBit = evIn[k] & ~prevQ[k];
        EDGE_FALL: hitBit = ~evIn[k] & prevQ[k];
        EDGE_BOTH: hitBit = evIn[k] ^ prevQ[k];
        default:   hitBit = 1'b0;
      endcase
    end
    assign hit[k] = hitBit;

    // R5: a masked line is never flagged at the next edge
    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
      maskVec[k] |=> !detOut[k]);

    // R4: reserved code keeps the line silent
    assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
      (kind == EDGE_OFF) |=> !detOut[k]);
  end

  assign live  = strb.collectEn & strb.refValid;
  assign gated = live ? (hit & ~maskVec) : '0;

  // Registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detQ <= '0;
      anyQ <= 1'b0;
    end else begin
      detQ <= gated;
      anyQ <= |gated;
    end
  end

  assign detOut = detQ;
  assign anyOut = anyQ;

  // R6: collection off gives a quiet output
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.collectEn |=> (detOut == '0));

  // R7: no events right after the reference is (re)captured
  assert_first_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.collectEn) |=> (detOut == '0));

  // R8: flag agrees with the vector
  assert_any_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyOut == (detOut != '0));

endmodule

// File: rtl/edge_sentinel.sv
module edge_sentinel
  import edge_sentinel_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WORD_W-1:0]    regWdata,
  output logic [WORD_W-1:0]    regRdata,
  input  logic [NUM_LINES-1:0] evIn,
  output logic [NUM_LINES-1:0] detOut,
  output logic                 anyOut
);

  senseStrobes_t          strb;
  logic [2*NUM_LINES-1:0] edgeSel;
  logic [NUM_LINES-1:0]   maskVec;

  edge_sentinel_regs #(
    .NUM_LINES(NUM_LINES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) i_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb),
    .edgeSel(edgeSel), .maskVec(maskVec)
  );

  edge_sentinel_core #(
    .NUM_LINES(NUM_LINES)
  ) i_core (
    .clk(clk), .rstN(rstN), .evIn(evIn), .strb(strb),
    .edgeSel(edgeSel), .maskVec(maskVec), .detOut(detOut), .anyOut(anyOut)
  );

endmodule

// File: tb/test_edge_sentinel.sv
module test_edge_sentinel;

  localparam int N = 256;
  localparam int W = 32;
  localparam int A = 6;
  localparam int CTRL0 = 1;
  localparam int MASK0 = 17;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [A-1:0] regAddr = '0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic [N-1:0] evIn = '0;
  logic [N-1:0] detOut;
  logic         anyOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  edge_sentinel #(.NUM_LINES(N), .WORD_W(W), .ADDR_W(A)) i_edge_sentinel (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evIn(evIn),
    .detOut(detOut), .anyOut(anyOut)
  );

  function automatic logic [N-1:0] bitOf(int n);
    return N'(1) << n;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(int addr, logic [W-1:0] data);
    regWe = 1'b1; regAddr = A'(addr); regWdata = data;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic checkDet(string req, logic [N-1:0] exp);
    testsRun++;
    if (detOut !== exp || anyOut !== (exp != '0)) begin
      testsFailed++;
      $display("FAIL %s: det=%h any=%b exp=%h any=%b", req, detOut, anyOut, exp, exp != '0);
    end
  endtask

  task automatic checkRead(string req, int addr, logic [W-1:0] exp);
    regAddr = A'(addr);
    #1;
    testsRun++;
    if (regRdata !== exp) begin
      testsFailed++;
      $display("FAIL %s: addr=%0d read=%h exp=%h", req, addr, regRdata, exp);
    end
  endtask

  task automatic t_reset_state();
    checkDet("R11 reset output", '0);
    checkRead("R6 switch reset", 0, '0);
    checkRead("R9 ctrl reset", CTRL0, '0);
    checkRead("R5 mask reset", MASK0, '0);
  endtask

  task automatic t_register_map();
    writeReg(MASK0 + 7, 32'h1234_5678);
    checkRead("R9 mask readback", MASK0 + 7, 32'h1234_5678);
    writeReg(MASK0 + 7, '0);
    writeReg(CTRL0 + 9, 32'hCAFE_0001);
    checkRead("R9 ctrl readback", CTRL0 + 9, 32'hCAFE_0001);
    writeReg(CTRL0 + 9, '0);
    checkRead("R9 unmapped", 40, '0);
  endtask

  task automatic t_enable();
    writeReg(0, 32'h1);
    checkRead("R6 switch readback", 0, 32'h1);
    step();
    step();
    checkDet("R7 quiet after enable", '0);
  endtask

  task automatic t_rising();
    evIn[5] = 1'b1; step();
    checkDet("R1 rise flagged", bitOf(5));
    step();
    checkDet("R11 one cycle only", '0);
    evIn[5] = 1'b0; step();
    checkDet("R1 fall ignored", '0);
  endtask

  task automatic t_falling();
    writeReg(CTRL0 + 1, 32'h1 << 8);  // line 20 -> falling
    evIn[20] = 1'b1; step();
    checkDet("R2 rise ignored", '0);
    evIn[20] = 1'b0; step();
    checkDet("R2 fall flagged", bitOf(20));
  endtask

  task automatic t_toggle();
    writeReg(CTRL0 + 2, 32'h2 << 30);  // line 47 -> toggle
    evIn[47] = 1'b1; step();
    checkDet("R3 toggle rise", bitOf(47));
    evIn[47] = 1'b0; step();
    checkDet("R3 toggle fall", bitOf(47));
  endtask

  task automatic t_reserved();
    writeReg(CTRL0 + 15, 32'h3 << 30);  // line 255 -> reserved
    evIn[255] = 1'b1; step();
    checkDet("R4 reserved rise", '0);
    evIn[255] = 1'b0; step();
    checkDet("R4 reserved fall", '0);
  endtask

  task automatic t_mask();
    writeReg(MASK0 + 3, 32'h1 << 4);  // mask line 100
    evIn[100] = 1'b1; evIn[101] = 1'b1; step();
    checkDet("R5 masked line silent, neighbour flagged", bitOf(101));
    evIn[100] = 1'b0; evIn[101] = 1'b0; step();
    checkDet("R5 falls ignored", '0);
    writeReg(MASK0 + 3, '0);
    evIn[100] = 1'b1; step();
    checkDet("R5 unmasked again", bitOf(100));
    evIn[100] = 1'b0; step();
  endtask

  task automatic t_any();
    evIn[5] = 1'b1; evIn[47] = 1'b1; evIn[20] = 1'b1; step();
    checkDet("R8 several lines", bitOf(5) | bitOf(47));
    evIn[5] = 1'b0; evIn[47] = 1'b0; evIn[20] = 1'b0; step();
    checkDet("R8 mixed kinds", bitOf(47) | bitOf(20));
    step();
    checkDet("R8 flag clear", '0);
  endtask

  task automatic t_same_cycle();
    regWe = 1'b1; regAddr = A'(CTRL0); regWdata = 32'h1 << 10;  // line 5 -> falling
    evIn[5] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
    checkDet("R10 old setting at write edge", bitOf(5));
    evIn[5] = 1'b0; step();
    checkDet("R10 new setting after write", bitOf(5));
  endtask

  task automatic t_disable();
    writeReg(0, '0);
    checkRead("R6 switch cleared", 0, '0);
    evIn[47] = 1'b1; step();
    checkDet("R6 disabled rise", '0);
    evIn[47] = 1'b0; step();
    checkDet("R6 disabled fall", '0);
    evIn[101] = 1'b1;
    writeReg(0, 32'h1);
    step();
    checkDet("R7 first cycle silent", '0);
    evIn[101] = 1'b0; step();
    checkDet("R1 fall after re-enable", '0);
    evIn[101] = 1'b1; step();
    checkDet("R7 detection resumes", bitOf(101));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_register_map();
    t_enable();
    t_rising();
    t_falling();
    t_toggle();
    t_reserved();
    t_mask();
    t_any();
    t_same_cycle();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule